// File: doc/BRIEF.md
# Multicore Bring-Up Configuration Registers

This block sits on a 32-bit register bus inside a 1 KiB address window and lets boot software release the secondary cores of a four-core cluster. Software first programs a boot-vector register with the address where a core should begin. It then writes any nonzero value to that core's reset-control register. The block answers with a single-cycle start request on a one-hot vector. The request carries the boot vector captured at that moment and a fixed starting privilege level of 3.

The block also holds a general-control word and a standby flag. Several registers return hard-wired status, reset-state and clock-gating values and ignore writes. Offsets that belong to features outside this block (debug and the 64-bit counter) read zero and raise an "unimplemented" pulse. Every other offset, every misaligned address and every partial-width access reads zero and raises an "invalid" pulse.

The request side uses valid/ready. `req_ready` is held high, so the block never applies back-pressure and accepts one request in every cycle where `req_valid` is high. Each accepted request gets exactly one response, marked by `rsp_valid`, in the following cycle. The response side has no ready signal and cannot be stalled.

Top module: `core_boot_cfg`

## Requirements
- R1: Reset is synchronous and active-low. After reset the boot vector reads 0, the general-control word reads 0x00000020 and the standby flag reads 0. `start_vec` is 0 during reset and in the first cycle after reset.
- R2: The boot vector (0x1A4), the general-control word (0x184) and the standby flag (0x1A0) are full 32-bit read/write registers.
- R3: Core i (i = 0..3) has a register group at 0x40 + 0x40*i. Its reset-control register (+0x0) reads 0x3, its control register (+0x4) reads 0 and its status register (+0x8) reads 0x1. Writes to the control and status registers change nothing.
- R4: The cluster reset register (0x000) and the system reset register (0x140) read 0x1. The clock-gating register (0x144) reads 0x10F. Writes to these three registers are ignored.
- R5: A write of a nonzero value to core i's reset-control register raises bit i of `start_vec` for exactly one cycle, the cycle after the request. During that cycle `start_addr` equals the boot vector value held when the request was made, and `start_el` equals 2'b11.
- R6: A write of zero to a reset-control register produces no start request.
- R7: Offsets 0x1E4, 0x280, 0x284 and 0x288 read 0 and ignore writes. An access to any of them raises `unimpl_pulse` for one cycle, the cycle after the request.
- R8: An access to any other offset, or to an address whose two low bits are nonzero, reads 0, changes no register and raises `invalid_pulse` in the cycle after the request.
- R9: An access whose `req_be` is not 4'hF writes nothing, starts no core, reads 0 and raises `invalid_pulse`.
- R10: `req_ready` is always 1. `rsp_valid` is 1 exactly in the cycle after each accepted request. `rsp_rdata` holds the read value for reads and 0 for writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Bus request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Byte offset within the window |
| req_be | input | 4 | Byte enables; only 4'hF is a valid access |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Read data |
| start_vec | output | 4 | One-hot start request per core |
| start_addr | output | 32 | Boot vector carried by the start request |
| start_el | output | 2 | Starting privilege level (3) |
| unimpl_pulse | output | 1 | Access to an unimplemented register |
| invalid_pulse | output | 1 | Access to an invalid offset or with an invalid width |

## Verification
Every result of this block comes from exactly one register stage. Read data, `rsp_valid`, the start vector with its address, and both flag pulses all appear in the cycle after the edge that accepts the request. A register write becomes visible to a read issued in the next request. The bench drives each request on a falling edge and samples the outputs shortly after the next rising edge. It then samples once more a cycle later, to confirm that every pulse has returned to zero and lasts only one cycle.

// File: rtl/cbc_pkg.sv
package cbc_pkg;

  localparam int unsigned DATA_W = 32;
  localparam int unsigned OFF_W  = 10;
  localparam int unsigned IDX_W  = 8;

  // offsets of fixed registers
  localparam logic [OFF_W-1:0] OFF_CLUSTER_RST = 10'h000;
  localparam logic [OFF_W-1:0] OFF_SYSTEM_RST  = 10'h140;
  localparam logic [OFF_W-1:0] OFF_CLK_GATE    = 10'h144;
  localparam logic [OFF_W-1:0] OFF_GEN_CTRL    = 10'h184;
  localparam logic [OFF_W-1:0] OFF_STANDBY     = 10'h1A0;
  localparam logic [OFF_W-1:0] OFF_BOOT_VEC    = 10'h1A4;
  localparam logic [OFF_W-1:0] OFF_DEBUG       = 10'h1E4;
  localparam logic [OFF_W-1:0] OFF_CNT_CTRL    = 10'h280;
  localparam logic [OFF_W-1:0] OFF_CNT_LO      = 10'h284;
  localparam logic [OFF_W-1:0] OFF_CNT_HI      = 10'h288;

  localparam logic [DATA_W-1:0] GEN_CTRL_RST  = 32'h0000_0020;
  localparam logic [DATA_W-1:0] CORE_RST_READ = 32'h0000_0003;
  localparam logic [DATA_W-1:0] CORE_STS_READ = 32'h0000_0001;
  localparam logic [DATA_W-1:0] SYS_RST_READ  = 32'h0000_0001;

  typedef enum logic [2:0] {
    K_INVALID,
    K_UNIMPL,
    K_CONST,
    K_GENCTL,
    K_STANDBY,
    K_BOOTVEC,
    K_CORE_RST
  } kind_e;

  typedef struct packed {
    kind_e             kind;
    logic [IDX_W-1:0]  core;
    logic [DATA_W-1:0] cval;
  } dec_t;

endpackage

// File: rtl/cbc_decode.sv
module cbc_decode
  import cbc_pkg::*;
#(
  parameter int unsigned NUM_CORES    = 4,
  parameter int unsigned GROUP_BASE   = 'h40,
  parameter int unsigned GROUP_STRIDE = 'h40
) (
  input  logic [OFF_W-1:0] off,
  input  logic [3:0]       be,
  output dec_t             dec
);

  localparam logic [DATA_W-1:0] CLK_GATE_READ =
    DATA_W'(32'h100 | ((32'h1 << NUM_CORES) - 32'h1));

  logic [NUM_CORES-1:0] rst_hit;
  logic [NUM_CORES-1:0] ctl_hit;
  logic [NUM_CORES-1:0] sts_hit;

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
    localparam logic [OFF_W-1:0] BASE = OFF_W'(GROUP_BASE + g * GROUP_STRIDE);
    assign rst_hit[g] = (off == BASE);
    assign ctl_hit[g] = (off == BASE + OFF_W'(4));
    assign sts_hit[g] = (off == BASE + OFF_W'(8));
  end

  logic well_formed;
  assign well_formed = (be == 4'hF) && (off[1:0] == 2'b00);

  always_comb begin
    dec.kind = K_INVALID;
    dec.core = '0;
    dec.cval = '0;
    if (well_formed) begin
      unique case (off)
        OFF_CLUSTER_RST, OFF_SYSTEM_RST: begin
          dec.kind = K_CONST;
          dec.cval = SYS_RST_READ;
        end
        OFF_CLK_GATE: begin
          dec.kind = K_CONST;
          dec.cval = CLK_GATE_READ;
        end
        OFF_GEN_CTRL: dec.kind = K_GENCTL;
        OFF_STANDBY:  dec.kind = K_STANDBY;
        OFF_BOOT_VEC: dec.kind = K_BOOTVEC;
        OFF_DEBUG, OFF_CNT_CTRL, OFF_CNT_LO, OFF_CNT_HI: dec.kind = K_UNIMPL;
        default: ;
      endcase
      for (int i = 0; i < NUM_CORES; i++) begin
        if (rst_hit[i]) begin
          dec.kind = K_CORE_RST;
          dec.core = IDX_W'(i);
          dec.cval = CORE_RST_READ;
        end
        if (ctl_hit[i]) begin
          dec.kind = K_CONST;
          dec.cval = '0;
        end
        if (sts_hit[i]) begin
          dec.kind = K_CONST;
          dec.cval = CORE_STS_READ;
        end
      end
    end
  end

endmodule

// File: rtl/cbc_regs.sv
module cbc_regs
  import cbc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic              wr,
  input  dec_t              dec,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] boot_vec,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              unimpl_pulse,
  output logic              invalid_pulse
);

  logic [DATA_W-1:0] gen_q, stby_q, vec_q;
  logic [DATA_W-1:0] rd_mux;
  logic              do_wr;

  assign do_wr    = acc && wr;
  assign boot_vec = vec_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gen_q  <= GEN_CTRL_RST;
      stby_q <= '0;
      vec_q  <= '0;
    end else if (do_wr) begin
      if (dec.kind == K_GENCTL)  gen_q  <= wdata;
      if (dec.kind == K_STANDBY) stby_q <= wdata;
      if (dec.kind == K_BOOTVEC) vec_q  <= wdata;
    end
  end

  always_comb begin
    unique case (dec.kind)
      K_CONST, K_CORE_RST: rd_mux = dec.cval;
      K_GENCTL:            rd_mux = gen_q;
      K_STANDBY:           rd_mux = stby_q;
      K_BOOTVEC:           rd_mux = vec_q;
      default:             rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_rdata     <= '0;
      unimpl_pulse  <= 1'b0;
      invalid_pulse <= 1'b0;
    end else begin
      rsp_valid     <= acc;
      rsp_rdata     <= (acc && !wr) ? rd_mux : '0;
      unimpl_pulse  <= acc && (dec.kind == K_UNIMPL);
      invalid_pulse <= acc && (dec.kind == K_INVALID);
    end
  end

endmodule

// File: rtl/cbc_start_gen.sv
module cbc_start_gen
  import cbc_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned START_EL  = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 acc,
  input  logic                 wr,
  input  dec_t                 dec,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [DATA_W-1:0]    boot_vec,
  output logic [NUM_CORES-1:0] start_vec,
  output logic [DATA_W-1:0]    start_addr,
  output logic [1:0]           start_el
);

  logic fire;
  assign fire     = acc && wr && (dec.kind == K_CORE_RST) && (wdata != '0);
  assign start_el = 2'(START_EL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_vec  <= '0;
      start_addr <= '0;
    end else begin
      start_vec <= '0;
      if (fire) begin
        start_vec  <= NUM_CORES'(1) << dec.core;
        start_addr <= boot_vec;
      end
    end
  end

endmodule

// File: rtl/core_boot_cfg.sv
module core_boot_cfg
  import cbc_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [9:0]           req_addr,
  input  logic [3:0]           req_be,
  input  logic [31:0]          req_wdata,
  output logic                 rsp_valid,
  output logic [31:0]          rsp_rdata,
  output logic [NUM_CORES-1:0] start_vec,
  output logic [31:0]          start_addr,
  output logic [1:0]           start_el,
  output logic                 unimpl_pulse,
  output logic                 invalid_pulse
);

  dec_t              dec;
  logic [DATA_W-1:0] boot_vec;
  logic              acc;

  assign req_ready = 1'b1;
  assign acc       = req_valid && req_ready;

  cbc_decode #(.NUM_CORES(NUM_CORES)) u_dec (
    .off (req_addr),
    .be  (req_be),
    .dec (dec)
  );

  cbc_regs u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .acc           (acc),
    .wr            (req_write),
    .dec           (dec),
    .wdata         (req_wdata),
    .boot_vec      (boot_vec),
    .rsp_valid     (rsp_valid),
    .rsp_rdata     (rsp_rdata),
    .unimpl_pulse  (unimpl_pulse),
    .invalid_pulse (invalid_pulse)
  );

  cbc_start_gen #(.NUM_CORES(NUM_CORES)) u_start (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc        (acc),
    .wr         (req_write),
    .dec        (dec),
    .wdata      (req_wdata),
    .boot_vec   (boot_vec),
    .start_vec  (start_vec),
    .start_addr (start_addr),
    .start_el   (start_el)
  );

endmodule

// File: rtl/cbc_checker.sv
module cbc_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_write,
  input logic [9:0]  req_addr,
  input logic [3:0]  req_be,
  input logic [31:0] req_wdata,
  input logic        rsp_valid,
  input logic [31:0] rsp_rdata,
  input logic [3:0]  start_vec,
  input logic [31:0] start_addr,
  input logic [1:0]  start_el,
  input logic        unimpl_pulse,
  input logic        invalid_pulse
);

  // R5
  start_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(start_vec));

  // R1
  no_start_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> start_vec == '0);

  // R5
  start_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_vec != '0) |-> $past(req_valid && req_write && req_be == 4'hF && req_wdata != '0));

  // R6
  zero_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && req_write && req_wdata == '0) |-> start_vec == '0);

  // R9
  partial_be_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && req_be != 4'hF) |-> (start_vec == '0 && invalid_pulse));

  // R10
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == $past(req_valid));

  // R7
  unimpl_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unimpl_pulse |-> (rsp_rdata == '0 && !invalid_pulse && rsp_valid));

  // R8
  invalid_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    invalid_pulse |-> (rsp_rdata == '0 && rsp_valid));

  // R10
  ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready);

endmodule

bind core_boot_cfg cbc_checker chk_i (.*);

// File: tb/core_boot_cfg_tb.sv
module core_boot_cfg_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [9:0]  req_addr = '0;
  logic [3:0]  req_be = 4'hF;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [3:0]  start_vec;
  logic [31:0] start_addr;
  logic [1:0]  start_el;
  logic        unimpl_pulse;
  logic        invalid_pulse;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // samples one cycle and two cycles after the request edge
  logic [31:0] g_rdata, g_addr;
  logic [3:0]  g_start, a_start;
  logic [1:0]  g_el;
  logic        g_rv, a_rv, g_un, a_un, g_inv, a_inv;

  always #(CLK_PERIOD/2) clk = ~clk;

  core_boot_cfg dut_i (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [9:0] a, input logic [31:0] d,
                        input logic [3:0] be);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_be = be;
    @(posedge clk); #1;
    g_rdata = rsp_rdata; g_addr = start_addr; g_start = start_vec; g_el = start_el;
    g_rv = rsp_valid; g_un = unimpl_pulse; g_inv = invalid_pulse;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_be = 4'hF; req_wdata = '0;
    @(posedge clk); #1;
    a_start = start_vec; a_rv = rsp_valid; a_un = unimpl_pulse; a_inv = invalid_pulse;
  endtask

  task automatic rd(input logic [9:0] a);
    access(1'b0, a, 32'h0, 4'hF);
  endtask

  task automatic wrt(input logic [9:0] a, input logic [31:0] d);
    access(1'b1, a, d, 4'hF);
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    #1 chk("R1 start_vec in reset", {28'h0, start_vec}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1 chk("R1 start_vec after reset", {28'h0, start_vec}, 32'h0);
    rd(10'h184); chk("R1 gen ctrl reset", g_rdata, 32'h20);
    rd(10'h1A0); chk("R1 standby reset", g_rdata, 32'h0);
    rd(10'h1A4); chk("R1 boot vector reset", g_rdata, 32'h0);
  endtask

  task automatic t_rw();
    wrt(10'h1A4, 32'hDEAD_BEE0); rd(10'h1A4); chk("R2 boot vector rw", g_rdata, 32'hDEAD_BEE0);
    wrt(10'h184, 32'hA5A5_5A5A); rd(10'h184); chk("R2 gen ctrl rw", g_rdata, 32'hA5A5_5A5A);
    wrt(10'h1A0, 32'hFFFF_FFFF); rd(10'h1A0); chk("R2 standby rw", g_rdata, 32'hFFFF_FFFF);
    rd(10'h1A4); chk("R2 boot vector kept", g_rdata, 32'hDEAD_BEE0);
  endtask

  task automatic t_core_regs();
    for (int i = 0; i < 4; i++) begin
      logic [9:0] b = 10'(32'h40 + 32'h40 * i);
      rd(b);         chk($sformatf("R3 core%0d rst read", i), g_rdata, 32'h3);
      wrt(b + 10'd4, 32'hFFFF_FFFF);
      rd(b + 10'd4); chk($sformatf("R3 core%0d ctrl read", i), g_rdata, 32'h0);
      wrt(b + 10'd8, 32'h0);
      rd(b + 10'd8); chk($sformatf("R3 core%0d status read", i), g_rdata, 32'h1);
    end
  endtask

  task automatic t_const();
    wrt(10'h000, 32'h0);  rd(10'h000); chk("R4 cluster rst", g_rdata, 32'h1);
    wrt(10'h140, 32'h0);  rd(10'h140); chk("R4 system rst", g_rdata, 32'h1);
    wrt(10'h144, 32'h0);  rd(10'h144); chk("R4 clock gating", g_rdata, 32'h10F);
  endtask

  task automatic t_start();
    wrt(10'h1A4, 32'h1234_5670);
    for (int i = 0; i < 4; i++) begin
      wrt(10'(32'h40 + 32'h40 * i), 32'h1);
      chk($sformatf("R5 core%0d start vec", i), {28'h0, g_start}, 32'h1 << i);
      chk($sformatf("R5 core%0d start addr", i), g_addr, 32'h1234_5670);
      chk($sformatf("R5 core%0d start el", i), {30'h0, g_el}, 32'h3);
      chk($sformatf("R5 core%0d one cycle", i), {28'h0, a_start}, 32'h0);
    end
    wrt(10'h1A4, 32'h8000_0040);
    wrt(10'h0C0, 32'h8000_0000);
    chk("R5 new vector start vec", {28'h0, g_start}, 32'h4);
    chk("R5 new vector addr", g_addr, 32'h8000_0040);
  endtask

  task automatic t_zero();
    wrt(10'h080, 32'h0);
    chk("R6 zero write no start", {28'h0, g_start}, 32'h0);
    chk("R6 zero write no start later", {28'h0, a_start}, 32'h0);
  endtask

  task automatic t_unimpl();
    rd(10'h1E4);
    chk("R7 debug reads zero", g_rdata, 32'h0);
    chk("R7 debug unimpl pulse", {31'h0, g_un}, 32'h1);
    chk("R7 unimpl one cycle", {31'h0, a_un}, 32'h0);
    chk("R7 not invalid", {31'h0, g_inv}, 32'h0);
    wrt(10'h280, 32'hFFFF_FFFF); chk("R7 counter write pulse", {31'h0, g_un}, 32'h1);
    rd(10'h288); chk("R7 counter reads zero", g_rdata, 32'h0);
    rd(10'h284); chk("R7 counter low pulse", {31'h0, g_un}, 32'h1);
  endtask

  task automatic t_invalid();
    rd(10'h3FC);
    chk("R8 unmapped reads zero", g_rdata, 32'h0);
    chk("R8 unmapped invalid pulse", {31'h0, g_inv}, 32'h1);
    chk("R8 invalid one cycle", {31'h0, a_inv}, 32'h0);
    wrt(10'h1A5, 32'h0000_FFFF);
    chk("R8 misaligned invalid", {31'h0, g_inv}, 32'h1);
    rd(10'h1A4); chk("R8 misaligned no write", g_rdata, 32'h8000_0040);
    rd(10'h04C); chk("R8 core gap invalid", {31'h0, g_inv}, 32'h1);
    wrt(10'h041, 32'h1); chk("R8 misaligned core rst no start", {28'h0, g_start}, 32'h0);
  endtask

  task automatic t_be();
    access(1'b1, 10'h1A4, 32'h0BAD_0000, 4'h3);
    chk("R9 partial be invalid", {31'h0, g_inv}, 32'h1);
    rd(10'h1A4); chk("R9 partial be no write", g_rdata, 32'h8000_0040);
    access(1'b1, 10'h040, 32'h0000_00FF, 4'h1);
    chk("R9 partial be no start", {28'h0, g_start}, 32'h0);
    access(1'b0, 10'h144, 32'h0, 4'hE);
    chk("R9 partial read zero", g_rdata, 32'h0);
  endtask

  task automatic t_timing();
    chk("R10 ready high", {31'h0, req_ready}, 32'h1);
    rd(10'h144);
    chk("R10 rsp valid next cycle", {31'h0, g_rv}, 32'h1);
    chk("R10 rsp valid drops", {31'h0, a_rv}, 32'h0);
    wrt(10'h184, 32'h5);
    chk("R10 write response data zero", g_rdata, 32'h0);
    chk("R10 write rsp valid", {31'h0, g_rv}, 32'h1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_rw();
    t_core_regs();
    t_const();
    t_start();
    t_zero();
    t_unimpl();
    t_invalid();
    t_be();
    t_timing();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

endmodule